// File: doc/BRIEF.md
# Tiled Address Swizzle Translator

This block takes a byte offset into a tiled two-dimensional surface and reports which linear pixel (dword) index is stored at that location. The surface is 512 dwords wide (a 2048-byte row pitch) and 512 rows tall, so offsets span 1 MiB and are treated as dword aligned. First, an optional channel swizzle folds up to three higher address bits into bit 6 of the offset. The swizzled offset is then split into a tile number and a position inside that tile. From these the block rebuilds the column (x) and row (y) of the dword and the combined linear index `y*512 + x`.

Two tile shapes can be selected per request. Shape 0 is 512 bytes wide by 8 rows (4096 bytes per tile). Shape 1 is 128 bytes wide by 16 rows (2048 bytes per tile). Tiles are laid out row-major across the surface pitch. A swizzle code the block does not support gives no result. The request still completes, but only with an error flag raised.

Requests enter and results leave through valid/ready handshakes, with one register stage between them. A consumer that holds back its ready signal stalls the result and blocks new requests. The reset input is active low: it asserts asynchronously and is released through a synchronizer outside the block.

Top module: `tswz_translator`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid` is 0 and `req_ready` is 1 until the first request is accepted.
- R2: `mode` selects which address bits are XORed into bit 6 of the offset: 0 none, 1 bit 9, 2 bits 9 and 10, 3 bits 9 and 11, 4 bits 9, 10 and 11. All other bits of `res_swz_off` equal the offset bits.
- R3: Offset bits [1:0] are ignored. `res_swz_off[1:0]` is always 0, and every result equals the result for the same offset with those two bits cleared.
- R4: With `geom` = 0, a tile is 512 bytes by 8 rows and there are 4 tiles per surface row. With tile = s/4096 and t = s%4096: y = (tile/4)*8 + t/512 and x = (tile%4)*128 + (t%512)/4.
- R5: With `geom` = 1, a tile is 128 bytes by 16 rows and there are 16 tiles per surface row. With tile = s/2048 and t = s%2048: y = (tile/16)*16 + t/128 and x = (tile%16)*32 + (t%128)/4.
- R6: `res_index` equals `res_y`*512 + `res_x`.
- R7: Modes 5, 6 and 7 give `res_err` = 1, with `res_swz_off`, `res_x`, `res_y` and `res_index` all 0. Supported modes give `res_err` = 0.
- R8: A request accepted on a clock edge (`req_valid` and `req_ready` both 1) is shown with `res_valid` = 1 right after that edge. With no new request and `res_ready` = 1, `res_valid` returns to 0 after the next edge.
- R9: While `res_valid` = 1 and `res_ready` = 0, the result outputs hold their values and `req_ready` is 0, so no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_off | input | 20 | Byte offset into the surface |
| req_mode | input | 3 | Swizzle mode code (0..4 valid) |
| req_geom | input | 1 | Tile shape select: 0 = 512B x 8, 1 = 128B x 16 |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_swz_off | output | 20 | Offset after bit-6 swizzle, low two bits zero |
| res_x | output | 9 | Dword column in the linear surface |
| res_y | output | 9 | Row in the linear surface |
| res_index | output | 18 | Linear dword index y*512 + x |
| res_err | output | 1 | Unsupported swizzle mode |

## Verification
A wrong swizzle term shows up in the first result whose offset has the affected bit set. `res_swz_off` bit 6 is then wrong, and the x column jumps by 16 dwords in the very next cycle after acceptance. A wrong shift or mask in a tile shape corrupts x or y for whole ranges of offsets. A dense sweep of the low offsets, together with a strided sweep of the full range, shows it within a few requests. Errors in the handshake register show as a result that changes or is lost while stalled, or as a valid that lingers one cycle too long. Both are visible on the cycle after the edge in question.

// File: rtl/tswz_pkg.sv
package tswz_pkg;

  // Swizzle mode codes; anything above SWZ_B9_10_11 is unsupported.
  typedef enum logic [2:0] {
    SWZ_NONE     = 3'd0,
    SWZ_B9       = 3'd1,
    SWZ_B9_10    = 3'd2,
    SWZ_B9_11    = 3'd3,
    SWZ_B9_10_11 = 3'd4
  } swz_mode_e;

  // Tile shape select.
  typedef enum logic {
    GEOM_WIDE   = 1'b0,
    GEOM_NARROW = 1'b1
  } geom_e;

  localparam int unsigned NUM_GEOM = 2;

endpackage

// File: rtl/tswz_bit6_xor.sv
module tswz_bit6_xor
  import tswz_pkg::*;
#(
  parameter int unsigned OFF_W = 20
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [2:0]       mode_i,
  output logic [OFF_W-1:0] swz_o,
  output logic             err_o
);

  logic flip;
  // Low two offset bits are dropped (dword alignment).
  logic [1:0] unused_low;
  assign unused_low = off_i[1:0];

  always_comb begin
    flip  = 1'b0;
    err_o = 1'b0;
    case (mode_i)
      SWZ_NONE:     flip = 1'b0;
      SWZ_B9:       flip = off_i[9];
      SWZ_B9_10:    flip = off_i[9] ^ off_i[10];
      SWZ_B9_11:    flip = off_i[9] ^ off_i[11];
      SWZ_B9_10_11: flip = off_i[9] ^ off_i[10] ^ off_i[11];
      default:      err_o = 1'b1;
    endcase
  end

  assign swz_o = {off_i[OFF_W-1:7], off_i[6] ^ flip, off_i[5:2], 2'b00};

endmodule

// File: rtl/tswz_tile_decode.sv
module tswz_tile_decode
  import tswz_pkg::*;
#(
  parameter int unsigned D_W        = 18,
  parameter int unsigned X_W        = 9,
  parameter int unsigned Y_W        = 9,
  parameter int unsigned PITCH_LOG2 = 11,
  parameter int unsigned TW0_LOG2   = 9,
  parameter int unsigned TH0_LOG2   = 3,
  parameter int unsigned TW1_LOG2   = 7,
  parameter int unsigned TH1_LOG2   = 4
) (
  input  logic [D_W-1:0]     dw_i,
  input  logic               geom_i,
  output logic [X_W-1:0]     x_o,
  output logic [Y_W-1:0]     y_o,
  output logic [X_W+Y_W-1:0] idx_o
);

  logic [X_W-1:0] cand_x [NUM_GEOM];
  logic [Y_W-1:0] cand_y [NUM_GEOM];

  for (genvar g = 0; g < NUM_GEOM; g++) begin : g_shape
    // Per-shape geometry, all in log2 form.
    localparam int unsigned TWB = (g == 0) ? TW0_LOG2 : TW1_LOG2; // tile width, bytes
    localparam int unsigned THL = (g == 0) ? TH0_LOG2 : TH1_LOG2; // tile height, rows
    localparam int unsigned TWD = TWB - 2;                        // tile width, dwords
    localparam int unsigned TSD = TWD + THL;                      // tile size, dwords
    localparam int unsigned TPR = PITCH_LOG2 - TWB;               // tiles per surface row
    localparam logic [D_W-1:0] TPR_MASK = D_W'((1 << TPR) - 1);
    localparam logic [D_W-1:0] TWD_MASK = D_W'((1 << TWD) - 1);
    localparam logic [D_W-1:0] THL_MASK = D_W'((1 << THL) - 1);

    // Column: tile column scaled by tile width, plus in-tile dword column.
    assign cand_x[g] = X_W'((((dw_i >> TSD) & TPR_MASK) << TWD) | (dw_i & TWD_MASK));
    // Row: tile row scaled by tile height, plus in-tile row.
    assign cand_y[g] = Y_W'((((dw_i >> TSD) >> TPR) << THL) | ((dw_i >> TWD) & THL_MASK));
  end

  assign x_o   = cand_x[geom_i];
  assign y_o   = cand_y[geom_i];
  assign idx_o = {y_o, x_o};

endmodule

// File: rtl/tswz_out_stage.sv
module tswz_out_stage #(
  parameter int unsigned OFF_W = 20,
  parameter int unsigned X_W   = 9,
  parameter int unsigned Y_W   = 9,
  localparam int unsigned I_W  = X_W + Y_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OFF_W-1:0] in_swz,
  input  logic [X_W-1:0]   in_x,
  input  logic [Y_W-1:0]   in_y,
  input  logic [I_W-1:0]   in_idx,
  input  logic             in_err,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OFF_W-1:0] out_swz,
  output logic [X_W-1:0]   out_x,
  output logic [Y_W-1:0]   out_y,
  output logic [I_W-1:0]   out_idx,
  output logic             out_err
);

  logic             v_q, v_d;
  logic             load;
  logic [OFF_W-1:0] swz_q, swz_d;
  logic [X_W-1:0]   x_q, x_d;
  logic [Y_W-1:0]   y_q, y_d;
  logic [I_W-1:0]   idx_q, idx_d;
  logic             err_q, err_d;

  assign in_ready = !v_q || out_ready;
  assign load     = in_valid && in_ready;

  // Next state: an unsupported mode yields blank result fields.
  always_comb begin
    v_d   = load ? 1'b1 : (v_q && !out_ready);
    err_d = in_err;
    swz_d = in_err ? '0 : in_swz;
    x_d   = in_err ? '0 : in_x;
    y_d   = in_err ? '0 : in_y;
    idx_d = in_err ? '0 : in_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      swz_q <= swz_d;
      x_q   <= x_d;
      y_q   <= y_d;
      idx_q <= idx_d;
      err_q <= err_d;
    end
  end

  assign out_valid = v_q;
  assign out_swz   = swz_q;
  assign out_x     = x_q;
  assign out_y     = y_q;
  assign out_idx   = idx_q;
  assign out_err   = err_q;

  // R1: idle stage accepts requests.
  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R3: published offset never carries the ignored low bits.
  p_low_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_swz[1:0] == 2'b00);

  // R6: index is composed from the published row and column.
  p_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_idx == {out_y, out_x});

  // R7: an error result carries no address data.
  p_err_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> (out_swz == '0 && out_x == '0 && out_y == '0 && out_idx == '0));

  // R8: an accepted request is visible after the edge.
  p_accept_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9: a stalled result holds and blocks new requests.
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_swz) && $stable(out_idx)
                               && $stable(out_err));
  p_stall_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

endmodule

// File: rtl/tswz_translator.sv
module tswz_translator
  import tswz_pkg::*;
#(
  parameter int unsigned SURF_W_LOG2 = 9,  // surface width in dwords
  parameter int unsigned SURF_H_LOG2 = 9,  // surface height in rows
  parameter int unsigned TW0_LOG2    = 9,  // shape 0 tile width, bytes
  parameter int unsigned TH0_LOG2    = 3,  // shape 0 tile height, rows
  parameter int unsigned TW1_LOG2    = 7,  // shape 1 tile width, bytes
  parameter int unsigned TH1_LOG2    = 4,  // shape 1 tile height, rows
  localparam int unsigned PITCH_LOG2 = SURF_W_LOG2 + 2,
  localparam int unsigned OFF_W      = SURF_W_LOG2 + SURF_H_LOG2 + 2,
  localparam int unsigned D_W        = OFF_W - 2,
  localparam int unsigned X_W        = SURF_W_LOG2,
  localparam int unsigned Y_W        = SURF_H_LOG2,
  localparam int unsigned I_W        = X_W + Y_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OFF_W-1:0] req_off,
  input  logic [2:0]       req_mode,
  input  logic             req_geom,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [OFF_W-1:0] res_swz_off,
  output logic [X_W-1:0]   res_x,
  output logic [Y_W-1:0]   res_y,
  output logic [I_W-1:0]   res_index,
  output logic             res_err
);

  logic [OFF_W-1:0] swz;
  logic             mode_err;
  logic [X_W-1:0]   dec_x;
  logic [Y_W-1:0]   dec_y;
  logic [I_W-1:0]   dec_idx;

  tswz_bit6_xor #(.OFF_W(OFF_W)) u_swz (
    .off_i  (req_off),
    .mode_i (req_mode),
    .swz_o  (swz),
    .err_o  (mode_err)
  );

  tswz_tile_decode #(
    .D_W        (D_W),
    .X_W        (X_W),
    .Y_W        (Y_W),
    .PITCH_LOG2 (PITCH_LOG2),
    .TW0_LOG2   (TW0_LOG2),
    .TH0_LOG2   (TH0_LOG2),
    .TW1_LOG2   (TW1_LOG2),
    .TH1_LOG2   (TH1_LOG2)
  ) u_dec (
    .dw_i   (swz[OFF_W-1:2]),
    .geom_i (req_geom),
    .x_o    (dec_x),
    .y_o    (dec_y),
    .idx_o  (dec_idx)
  );

  tswz_out_stage #(.OFF_W(OFF_W), .X_W(X_W), .Y_W(Y_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_swz    (swz),
    .in_x      (dec_x),
    .in_y      (dec_y),
    .in_idx    (dec_idx),
    .in_err    (mode_err),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_swz   (res_swz_off),
    .out_x     (res_x),
    .out_y     (res_y),
    .out_idx   (res_index),
    .out_err   (res_err)
  );

endmodule

// File: tb/tb_tswz_translator.sv
module tb_tswz_translator;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_off = '0;
  logic [2:0]  req_mode = '0;
  logic        req_geom = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [19:0] res_swz_off;
  logic [8:0]  res_x, res_y;
  logic [17:0] res_index;
  logic        res_err;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tswz_translator dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_off(req_off), .req_mode(req_mode), .req_geom(req_geom),
    .res_valid(res_valid), .res_ready(res_ready), .res_swz_off(res_swz_off),
    .res_x(res_x), .res_y(res_y), .res_index(res_index), .res_err(res_err)
  );

  task automatic check(input string tag, input bit ok, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected result built from the requirement arithmetic.
  function automatic logic [57:0] expect_of(input int off, input int mode, input int geom);
    int s, b6, tw, th, ts, tpr, tile, t, x, y;
    bit err;
    s   = off & ~3;
    b6  = 0;
    err = 0;
    case (mode)
      0: b6 = 0;
      1: b6 = (s >> 9) & 1;
      2: b6 = ((s >> 9) ^ (s >> 10)) & 1;
      3: b6 = ((s >> 9) ^ (s >> 11)) & 1;
      4: b6 = ((s >> 9) ^ (s >> 10) ^ (s >> 11)) & 1;
      default: err = 1;
    endcase
    s = s ^ (b6 << 6);
    if (geom == 0) begin tw = 512; th = 8;  end
    else           begin tw = 128; th = 16; end
    ts   = tw * th;
    tpr  = 2048 / tw;
    tile = s / ts;
    t    = s % ts;
    y    = (tile / tpr) * th + t / tw;
    x    = (tile % tpr) * (tw / 4) + (t % tw) / 4;
    if (err) return {1'b1, 57'd0};
    return {1'b0, s[19:0], y[8:0], x[8:0], 18'(y * 512 + x), 1'b0};
  endfunction

  function automatic logic [57:0] actual_now();
    return {res_err, res_swz_off, res_y, res_x, res_index, 1'b0};
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic xact(input string tag, input int off, input int mode, input int geom);
    logic [57:0] e;
    req_off   = 20'(off);
    req_mode  = 3'(mode);
    req_geom  = geom[0];
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    e = expect_of(off, mode, geom);
    check(tag, res_valid && actual_now() == e, 64'(actual_now()), 64'(e));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [57:0] held;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", res_valid == 1'b0, 64'(res_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", res_valid == 1'b0, 64'(res_valid), 64'd0);
    check("R1 ready after reset", req_ready == 1'b1, 64'(req_ready), 64'd1);

    // Dense sweep of the first 8 KiB, every mode, both shapes; low bits vary (R3).
    for (int g = 0; g < 2; g++)
      for (int m = 0; m < 5; m++)
        for (int k = 0; k < 2048; k++)
          xact(g == 0 ? "R4 R2 R3 R6 dense" : "R5 R2 R3 R6 dense", k * 4 + (k % 4), m, g);

    // Strided sweep across the full surface.
    for (int g = 0; g < 2; g++)
      for (int m = 0; m < 5; m++)
        for (int k = 0; k < 1024; k++)
          xact(g == 0 ? "R4 R2 R6 stride" : "R5 R2 R6 stride", (k * 4196 + 3) % (1 << 20), m, g);

    // Corners: last dword, tile boundaries.
    xact("R4 last dword", 20'hFFFFC, 0, 0);
    xact("R5 last dword", 20'hFFFFF, 4, 1);
    xact("R4 tile edge", 4095, 2, 0);
    xact("R5 tile edge", 2048, 3, 1);

    // Unsupported codes.
    for (int m = 5; m < 8; m++)
      for (int g = 0; g < 2; g++)
        for (int k = 0; k < 16; k++)
          xact("R7 bad mode", k * 65604 + 1, m, g);

    // Latency: valid drops one edge after the last request.
    xact("R8 single", 1234 * 4, 1, 0);
    @(negedge clk);
    check("R8 valid drops", res_valid == 1'b0, 64'(res_valid), 64'd0);

    // Backpressure.
    res_ready = 1'b0;
    req_off = 20'h12344; req_mode = 3'd2; req_geom = 1'b1; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    held = expect_of(32'h12344, 2, 1);
    check("R9 first result", res_valid && actual_now() == held, 64'(actual_now()), 64'(held));
    check("R9 ready low", req_ready == 1'b0, 64'(req_ready), 64'd0);
    req_off = 20'h00A40; req_mode = 3'd4; req_geom = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R9 held", res_valid && actual_now() == held, 64'(actual_now()), 64'(held));
    end
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    held = expect_of(32'h00A40, 4, 0);
    check("R9 second after release", res_valid && actual_now() == held,
          64'(actual_now()), 64'(held));
    @(negedge clk);
    check("R8 idle after drain", res_valid == 1'b0, 64'(res_valid), 64'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule